// File: doc/BRIEF.md
# Load Data Aligner and Extender

This block sits between a 32-bit read data bus and the register write-back port of a small load/store core. For every accepted load it takes the raw bus word, the two low address bits and a short descriptor of the access. The descriptor gives the access size, whether the result is signed, whether the read is the first half of an atomic swap, and whether the destination register is the program counter. From these it forms the 32-bit value that is written back.

A word load whose address is not word-aligned is neither faulted nor forced to alignment. The bus word is rotated right so that the addressed byte lands in the low lane. Byte and halfword loads take their lane from the address and fill the upper bits with zeros or with copies of the sign bit. A parameter selects the core variant on which a word load into the program counter has its bit 0 cleared. The result is registered, and a valid flag follows the input strobe by one clock.

Top module: `ld_align`

## Requirements
- R1: With size code 2'b10, swap low and strobe high, the result is the bus word rotated right by 8 × addr_lo bits.
- R2: With swap high and size code 2'b10, the result uses the same rotation as R1. A swap access ignores sgn, so a swap byte is zero-extended.
- R3: An unsigned byte load (size 2'b00, sgn low) returns bus byte addr_lo (bits 8·addr_lo+7 down to 8·addr_lo) in bits 7:0, with bits 31:8 zero.
- R4: A signed byte load (size 2'b00, sgn high, swap low) copies bit 7 of the selected byte into bits 31:8.
- R5: An unsigned halfword load (size 2'b01, sgn low) takes bus bits 31:16 when addr_lo[1] is 1 and bits 15:0 otherwise. addr_lo[0] is ignored, and bits 31:16 of the result are zero.
- R6: A signed halfword load (size 2'b01, sgn high, swap low) copies bit 15 of the selected halfword into bits 31:16.
- R7: When PC_CLR_BIT0 is 1, a non-swap word load with to_pc high has bit 0 of the result cleared. Swap loads and byte or halfword loads with to_pc high are returned unchanged.
- R8: out_vld equals in_vld from one clock earlier. While in_vld is low, out_vld is low and wdata keeps its last value.
- R9: During reset and right after it, out_vld is 0 and wdata is 0.
- R10: Size code 2'b11 behaves exactly like 2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | A load result is on the bus this cycle |
| rdata | input | DATA_W | Raw bus word |
| addr_lo | input | 2 | Low address bits of the access |
| size | input | 2 | 00 byte, 01 halfword, 10/11 word |
| sgn | input | 1 | Sign-extend a byte or halfword |
| swap | input | 1 | Read part of an atomic swap |
| to_pc | input | 1 | Destination is the program counter |
| out_vld | output | 1 | wdata holds a new result |
| wdata | output | DATA_W | Value for the register file |

## Verification
Word loads use a bus word whose four bytes are all distinct, at each of the four offsets, so any wrong rotation amount shows up. Byte and halfword loads use words that mix lanes with the top bit set and lanes with it clear. This separates sign extension from zero extension and exposes a wrong lane choice, including halfword offsets that differ only in bit 0. Program-counter loads use odd data to show that bit 0 is cleared only for non-swap word loads. Back-to-back strobes and idle gaps show that the output follows the strobe by one cycle and holds its value while the strobe is low.

// File: rtl/ld_align_pkg.sv
package ld_align_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE     = 2'b00,
        SZ_HALF     = 2'b01,
        SZ_WORD     = 2'b10,
        SZ_WORD_ALT = 2'b11
    } ld_size_e;

    typedef struct packed {
        ld_size_e size;
        logic     sgn;
        logic     swap;
        logic     to_pc;
    } ld_desc_t;

endpackage

// File: rtl/ld_lane_pick.sv
module ld_lane_pick #(
    parameter int DATA_W = 32,
    parameter int OFS_W  = $clog2(DATA_W / 8)
) (
    input  logic [DATA_W-1:0] rdata,
    input  logic [OFS_W-1:0]  ofs,
    output logic [DATA_W-1:0] rot_word,
    output logic [7:0]        byte_sel,
    output logic [15:0]       half_sel
);
    localparam int LANES = DATA_W / 8;

    logic [7:0] lane [LANES];

    // split the bus word into byte lanes, then rebuild it rotated
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane[g] = rdata[8*g +: 8];
        assign rot_word[8*g +: 8] = lane[OFS_W'(g + int'(ofs))];
    end

    assign byte_sel = lane[ofs];
    assign half_sel = {lane[{ofs[OFS_W-1:1], 1'b1}], lane[{ofs[OFS_W-1:1], 1'b0}]};

endmodule

// File: rtl/ld_extend.sv
module ld_extend
    import ld_align_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter bit PC_CLR_BIT0 = 1'b1
) (
    input  ld_desc_t          desc,
    input  logic [DATA_W-1:0] rot_word,
    input  logic [7:0]        byte_sel,
    input  logic [15:0]       half_sel,
    output logic [DATA_W-1:0] value
);
    logic do_sign;

    always_comb begin
        do_sign = desc.sgn && !desc.swap;
        value   = rot_word;
        unique case (desc.size)
            SZ_BYTE: value = do_sign ? {{(DATA_W-8){byte_sel[7]}}, byte_sel}
                                     : {{(DATA_W-8){1'b0}}, byte_sel};
            SZ_HALF: value = do_sign ? {{(DATA_W-16){half_sel[15]}}, half_sel}
                                     : {{(DATA_W-16){1'b0}}, half_sel};
            default: begin
                value = rot_word;
                if (PC_CLR_BIT0 && desc.to_pc && !desc.swap) value[0] = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/ld_align.sv
module ld_align
    import ld_align_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter bit PC_CLR_BIT0 = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic [DATA_W-1:0] rdata,
    input  logic [1:0]        addr_lo,
    input  logic [1:0]        size,
    input  logic              sgn,
    input  logic              swap,
    input  logic              to_pc,
    output logic              out_vld,
    output logic [DATA_W-1:0] wdata
);
    localparam int OFS_W = $clog2(DATA_W / 8);

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] data;
    } st_t;

    st_t               st_d, st_q;
    ld_desc_t          desc;
    logic [DATA_W-1:0] rot_word, ext_val;
    logic [7:0]        byte_sel;
    logic [15:0]       half_sel;

    assign desc = '{size: ld_size_e'(size), sgn: sgn, swap: swap, to_pc: to_pc};

    ld_lane_pick #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_pick (
        .rdata    (rdata),
        .ofs      (OFS_W'(addr_lo)),
        .rot_word (rot_word),
        .byte_sel (byte_sel),
        .half_sel (half_sel)
    );

    ld_extend #(.DATA_W(DATA_W), .PC_CLR_BIT0(PC_CLR_BIT0)) u_ext (
        .desc     (desc),
        .rot_word (rot_word),
        .byte_sel (byte_sel),
        .half_sel (half_sel),
        .value    (ext_val)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_vld;
        if (in_vld) st_d.data = ext_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_vld = st_q.vld;
    assign wdata   = st_q.data;

endmodule

// File: rtl/ld_align_chk.sv
module ld_align_chk #(
    parameter int DATA_W      = 32,
    parameter bit PC_CLR_BIT0 = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_vld,
    input logic [1:0]        size,
    input logic              sgn,
    input logic              swap,
    input logic              to_pc,
    input logic              out_vld,
    input logic [DATA_W-1:0] wdata
);
    AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld); // R8
    AST_IDLE_NO_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> !out_vld); // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> $stable(wdata)); // R8
    AST_UBYTE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && size == 2'b00 && (!sgn || swap)) |=> wdata[DATA_W-1:8] == '0); // R3
    AST_SBYTE_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && size == 2'b00 && sgn && !swap) |=> wdata[DATA_W-1:8] == {(DATA_W-8){wdata[7]}}); // R4
    AST_UHALF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && size == 2'b01 && (!sgn || swap)) |=> wdata[DATA_W-1:16] == '0); // R5
    AST_SHALF_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && size == 2'b01 && sgn && !swap) |=> wdata[DATA_W-1:16] == {(DATA_W-16){wdata[15]}}); // R6
    AST_PC_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
        (PC_CLR_BIT0 && in_vld && size[1] && to_pc && !swap) |=> !wdata[0]); // R7
endmodule

bind ld_align ld_align_chk #(.DATA_W(DATA_W), .PC_CLR_BIT0(PC_CLR_BIT0)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_vld  (in_vld),
    .size    (size),
    .sgn     (sgn),
    .swap    (swap),
    .to_pc   (to_pc),
    .out_vld (out_vld),
    .wdata   (wdata)
);

// File: tb/sim_ld_align.sv
`timescale 1ns/1ps
module sim_ld_align;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_vld = 1'b0;
    logic [31:0] rdata = '0;
    logic [1:0]  addr_lo = '0;
    logic [1:0]  size = '0;
    logic        sgn = 1'b0, swap = 1'b0, to_pc = 1'b0;
    logic        out_vld;
    logic [31:0] wdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [31:0] exp_q[$];
    string       req_q[$];
    logic [31:0] last_val = '0;

    always #4 clk = ~clk;

    ld_align u0 (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .rdata(rdata), .addr_lo(addr_lo),
        .size(size), .sgn(sgn), .swap(swap), .to_pc(to_pc), .out_vld(out_vld), .wdata(wdata)
    );

    function automatic logic [31:0] model(input logic [31:0] rd, input logic [1:0] a,
                                          input logic [1:0] sz, input logic sg,
                                          input logic sw, input logic pc);
        logic [31:0] r;
        logic [7:0]  b;
        logic [15:0] h;
        logic        s;
        s = sg && !sw;
        b = rd[8*a +: 8];
        h = a[1] ? rd[31:16] : rd[15:0];
        if (sz == 2'b00) begin
            r = s ? {{24{b[7]}}, b} : {24'h0, b};
        end else if (sz == 2'b01) begin
            r = s ? {{16{h[15]}}, h} : {16'h0, h};
        end else begin
            for (int i = 0; i < 4; i++) r[8*i +: 8] = rd[8*((i + a) % 4) +: 8];
            if (pc && !sw) r[0] = 1'b0;
        end
        return r;
    endfunction

    task automatic issue(input logic [31:0] rd, input logic [1:0] a, input logic [1:0] sz,
                         input logic sg, input logic sw, input logic pc, input string req);
        @(negedge clk);
        in_vld = 1'b1; rdata = rd; addr_lo = a; size = sz; sgn = sg; swap = sw; to_pc = pc;
        exp_q.push_back(model(rd, a, sz, sg, sw, pc));
        req_q.push_back(req);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_vld = 1'b0;
            rdata  = $urandom;
            sgn    = ~sgn;
        end
    endtask

    // monitor: pops expected results as the design presents them
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (out_vld) begin
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL R8 unexpected out_vld actual=1 expected=0");
                end else begin
                    logic [31:0] e;
                    string       r;
                    e = exp_q.pop_front();
                    r = req_q.pop_front();
                    if (wdata !== e) begin
                        errors++;
                        $display("FAIL %s wdata actual=%h expected=%h", r, wdata, e);
                    end
                    last_val = e;
                end
            end else begin
                checks++; // R8 hold while idle
                if (wdata !== last_val) begin
                    errors++;
                    $display("FAIL R8 hold actual=%h expected=%h", wdata, last_val);
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++; // R9
        if (out_vld !== 1'b0 || wdata !== 32'h0) begin
            errors++;
            $display("FAIL R9 reset actual=%b/%h expected=0/00000000", out_vld, wdata);
        end
        rst_n = 1'b1;
        idle(2);
        // R1 word rotation at each offset
        for (int a = 0; a < 4; a++) issue(32'h11223344, 2'(a), 2'b10, 1'b0, 1'b0, 1'b0, "R1");
        idle(2);
        // R10 alternate word code
        issue(32'hA1B2C3D4, 2'd3, 2'b11, 1'b1, 1'b0, 1'b0, "R10");
        issue(32'hA1B2C3D4, 2'd1, 2'b11, 1'b0, 1'b0, 1'b0, "R10");
        // R2 swap word and swap byte
        issue(32'hCAFEF00D, 2'd2, 2'b10, 1'b0, 1'b1, 1'b0, "R2");
        issue(32'h00F00000, 2'd2, 2'b00, 1'b1, 1'b1, 1'b0, "R2");
        idle(1);
        // R3 / R4 bytes
        for (int a = 0; a < 4; a++) issue(32'h7F80FF01, 2'(a), 2'b00, 1'b0, 1'b0, 1'b0, "R3");
        for (int a = 0; a < 4; a++) issue(32'h7F80FF01, 2'(a), 2'b00, 1'b1, 1'b0, 1'b0, "R4");
        idle(3);
        // R5 / R6 halfwords, bit 0 ignored
        for (int a = 0; a < 4; a++) issue(32'h8001_7FFE, 2'(a), 2'b01, 1'b0, 1'b0, 1'b0, "R5");
        for (int a = 0; a < 4; a++) issue(32'h8001_7FFE, 2'(a), 2'b01, 1'b1, 1'b0, 1'b0, "R6");
        issue(32'h7FFE_8001, 2'd1, 2'b01, 1'b1, 1'b0, 1'b0, "R6");
        idle(1);
        // R7 program counter rule
        issue(32'h00001235, 2'd0, 2'b10, 1'b0, 1'b0, 1'b1, "R7");
        issue(32'h35000012, 2'd3, 2'b10, 1'b0, 1'b0, 1'b1, "R7");
        issue(32'h00001235, 2'd0, 2'b10, 1'b0, 1'b1, 1'b1, "R7");
        issue(32'h000000FF, 2'd0, 2'b00, 1'b0, 1'b0, 1'b1, "R7");
        issue(32'h12345679, 2'd0, 2'b11, 1'b0, 1'b0, 1'b1, "R7");
        idle(4);
        checks++; // R8 every item produced
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R8 pending items actual=%0d expected=0", exp_q.size());
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule